// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Selector

This block holds the replacement state of a four-way set-associative cache, one small record per set. Each record is three bits that form a binary decision tree approximating least-recently-used order. A lookup names a set and gives the per-way valid vector. The block then returns, combinationally, the way to be replaced in that set. An access strobe with a way number updates the tree of the addressed set at the next clock edge, so that the way just used moves away from the victim path.

An empty slot always wins over the tree. If any way of the set is invalid, the lowest-numbered invalid way becomes the victim and the tree is not consulted. When all four ways are valid, the tree is walked. The root bit `tree[0]` chooses between the pair {0,1} and the pair {2,3}. `tree[1]` then chooses inside the low pair and `tree[2]` inside the high pair. In each bit, 1 means the left side (lower way) was used more recently.

Top module: `plru_set_selector`

## Requirements
- R1: After reset every set's tree is 000, so with all ways valid the victim of every set is way 0.
- R2: When `way_valid` is not all ones, `victim_way` is the lowest index whose valid bit is 0, whatever the tree holds.
- R3: With all ways valid the victim is found by walking the tree. Root 0 picks way 0 if `tree[1]`=0 and way 1 otherwise. Root 1 picks way 2 if `tree[2]`=0 and way 3 otherwise.
- R4: An access to way 0 sets `tree[0]` and `tree[1]` to 1 and leaves `tree[2]` unchanged.
- R5: An access to way 1 sets `tree[0]` to 1, clears `tree[1]` and leaves `tree[2]` unchanged.
- R6: An access to way 2 clears `tree[0]`, sets `tree[2]` to 1 and leaves `tree[1]` unchanged.
- R7: An access to way 3 clears `tree[0]` and `tree[2]` and leaves `tree[1]` unchanged.
- R8: With `acc_valid` low, no tree changes, whatever `acc_way` and `set_idx` carry.
- R9: An access changes only the tree of the set named by `set_idx`; all other sets keep their state.
- R10: `victim_way` follows `set_idx` and `way_valid` within the same cycle. A tree update becomes visible on `victim_way` only after the clock edge on which `acc_valid` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_idx | input | $clog2(NUM_SETS) | Set read for the victim and written on an access |
| acc_valid | input | 1 | Access strobe; updates the addressed tree at the clock edge |
| acc_way | input | 2 | Way that was accessed |
| way_valid | input | 4 | Per-way valid bits of the addressed set |
| victim_way | output | 2 | Way chosen for replacement |

## Verification
The hardest behaviour to show from the ports is that an update keeps the bit of the opposite subtree. The victim reveals only the branch the root points at, and each access turns the root away from its own pair. The stimulus therefore first sets the far bit with an access on the other side. It then accesses the near side and reads the victim with all ways valid; the root now points at the far pair, so the kept bit decides the result. A long pseudo-random sequence of accesses over several sets, checked against a model written from the update rules, covers the remaining tree states.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int unsigned WAYS   = 4;
  localparam int unsigned WAY_W  = 2;
  localparam int unsigned TREE_W = WAYS - 1;

  typedef logic [WAY_W-1:0]  way_idx_t;
  typedef logic [TREE_W-1:0] tree_bits_t;
endpackage

// File: rtl/plru_tree_update.sv
module plru_tree_update
  import plru_pkg::*;
(
  input  tree_bits_t tree_cur,
  input  way_idx_t   hit_way,
  output tree_bits_t tree_nxt
);
  // Point every bit on the path of the used way toward it; the other
  // subtree bit is carried over.
  always_comb begin
    tree_nxt = tree_cur;
    unique case (hit_way)
      2'd0: begin tree_nxt[0] = 1'b1; tree_nxt[1] = 1'b1; end
      2'd1: begin tree_nxt[0] = 1'b1; tree_nxt[1] = 1'b0; end
      2'd2: begin tree_nxt[0] = 1'b0; tree_nxt[2] = 1'b1; end
      default: begin tree_nxt[0] = 1'b0; tree_nxt[2] = 1'b0; end
    endcase
  end
endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick
  import plru_pkg::*;
(
  input  tree_bits_t       tree,
  input  logic [WAYS-1:0]  way_valid,
  output way_idx_t         victim
);
  logic     any_empty;
  way_idx_t first_empty;
  way_idx_t tree_choice;

  always_comb begin
    any_empty   = ~&way_valid;
    first_empty = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_valid[i]) first_empty = way_idx_t'(i);
    end
  end

  always_comb begin
    if (!tree[0]) tree_choice = tree[1] ? 2'd1 : 2'd0;
    else          tree_choice = tree[2] ? 2'd3 : 2'd2;
  end

  assign victim = any_empty ? first_empty : tree_choice;
endmodule

// File: rtl/plru_state_array.sv
module plru_state_array
  import plru_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] set_idx,
  input  tree_bits_t       wr_data,
  output tree_bits_t       rd_data
);
  tree_bits_t [NUM_SETS-1:0] mem_q;
  tree_bits_t [NUM_SETS-1:0] mem_d;
  logic       [NUM_SETS-1:0] row_en;

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_row
    assign row_en[g] = wr_en && (set_idx == SET_W'(g));

    always_comb begin
      mem_d[g] = mem_q[g];
      if (row_en[g]) mem_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mem_q[g] <= '0;
      else if (row_en[g]) mem_q[g] <= mem_d[g];
    end
  end

  assign rd_data = mem_q[set_idx];

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));

  // R9
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_en) <= 1);
endmodule

// File: rtl/plru_set_selector.sv
module plru_set_selector
  import plru_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic             acc_valid,
  input  logic [1:0]       acc_way,
  input  logic [3:0]       way_valid,
  output logic [1:0]       victim_way
);
  tree_bits_t tree_cur;
  tree_bits_t tree_nxt;

  plru_state_array #(.NUM_SETS(NUM_SETS)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_valid),
    .set_idx (set_idx),
    .wr_data (tree_nxt),
    .rd_data (tree_cur)
  );

  plru_tree_update u_update (
    .tree_cur (tree_cur),
    .hit_way  (acc_way),
    .tree_nxt (tree_nxt)
  );

  plru_victim_pick u_pick (
    .tree      (tree_cur),
    .way_valid (way_valid),
    .victim    (victim_way)
  );

  // R2
  empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&way_valid) |-> !way_valid[victim_way]);

  // R3
  root_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&way_valid) && !tree_cur[0] |-> !victim_way[1]);

  // R4
  way0_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(acc_valid) && $past(acc_way) == 2'd0
      && set_idx == $past(set_idx)
    |-> tree_cur[1:0] == 2'b11 && tree_cur[2] == $past(tree_cur[2]));

  // R7
  way3_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(acc_valid) && $past(acc_way) == 2'd3
      && set_idx == $past(set_idx)
    |-> tree_cur[0] == 1'b0 && tree_cur[2] == 1'b0
        && tree_cur[1] == $past(tree_cur[1]));
endmodule

// File: tb/plru_set_selector_test.sv
module plru_set_selector_test;
  localparam int unsigned NUM_SETS = 16;
  localparam int unsigned SET_W    = $clog2(NUM_SETS);

  logic             clk;
  logic             rst_n;
  logic [SET_W-1:0] set_idx;
  logic             acc_valid;
  logic [1:0]       acc_way;
  logic [3:0]       way_valid;
  logic [1:0]       victim_way;

  int vectors;
  int miscompares;
  bit finished;
  logic [2:0] model [NUM_SETS];

  plru_set_selector #(.NUM_SETS(NUM_SETS)) uut (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_valid(acc_valid),
    .acc_way(acc_way), .way_valid(way_valid), .victim_way(victim_way)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [1:0] exp_victim(logic [2:0] t, logic [3:0] v);
    if (v != 4'hF) begin
      for (int i = 0; i < 4; i++) if (!v[i]) return 2'(i);
    end
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [2:0] exp_update(logic [2:0] t, logic [1:0] w);
    logic [2:0] r = t;
    case (w)
      2'd0: begin r[0] = 1; r[1] = 1; end
      2'd1: begin r[0] = 1; r[1] = 0; end
      2'd2: begin r[0] = 0; r[2] = 1; end
      default: begin r[0] = 0; r[2] = 0; end
    endcase
    return r;
  endfunction

  task automatic check(int act, int exp, string req);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic peek(int s, logic [3:0] v, string req);
    set_idx = SET_W'(s); way_valid = v; #1;
    check(victim_way, exp_victim(model[s], v), req);
  endtask

  task automatic access(int s, logic [1:0] w);
    @(negedge clk);
    set_idx = SET_W'(s); acc_way = w; acc_valid = 1'b1;
    @(posedge clk);
    model[s] = exp_update(model[s], w);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    acc_valid = 0; acc_way = 0; set_idx = 0; way_valid = 4'hF; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int s = 0; s < NUM_SETS; s++) begin
      model[s] = 3'b000;
      set_idx = SET_W'(s); #1;
      check(victim_way, 0, "R1");
    end
  endtask

  task automatic t_empty;
    access(3, 2'd0); access(3, 2'd3);
    for (int v = 0; v < 15; v++) peek(3, 4'(v), "R2");
  endtask

  task automatic t_walk;
    access(7, 2'd0); peek(7, 4'hF, "R3"); // tree 011 -> way 2
    access(7, 2'd2); peek(7, 4'hF, "R3"); // tree 110 -> way 1
    access(7, 2'd1); peek(7, 4'hF, "R3"); // tree 101 -> way 3
    access(7, 2'd3); peek(7, 4'hF, "R3"); // tree 000 -> way 0
  endtask

  task automatic t_updates;
    // far bit set first, then near access: root turns to far side
    access(1, 2'd2); access(1, 2'd0); peek(1, 4'hF, "R4"); check(victim_way, 3, "R4");
    access(1, 2'd3); access(1, 2'd1); peek(1, 4'hF, "R5"); check(victim_way, 2, "R5");
    access(2, 2'd0); access(2, 2'd2); peek(2, 4'hF, "R6"); check(victim_way, 1, "R6");
    access(2, 2'd1); access(2, 2'd3); peek(2, 4'hF, "R7"); check(victim_way, 0, "R7");
  endtask

  task automatic t_idle;
    access(9, 2'd0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      acc_valid = 0; acc_way = 2'(k); set_idx = SET_W'(k + 8);
    end
    peek(9, 4'hF, "R8"); check(victim_way, 2, "R8");
  endtask

  task automatic t_sets;
    peek(4, 4'hF, "R9"); peek(6, 4'hF, "R9");
    access(5, 2'd0); access(5, 2'd2);
    peek(4, 4'hF, "R9"); check(victim_way, 0, "R9");
    peek(6, 4'hF, "R9"); check(victim_way, 0, "R9");
    peek(5, 4'hF, "R9");
  endtask

  task automatic t_timing;
    peek(10, 4'b1011, "R10"); check(victim_way, 2, "R10");
    peek(10, 4'hF, "R10");    check(victim_way, 0, "R10");
    @(negedge clk);
    set_idx = SET_W'(10); acc_way = 2'd0; acc_valid = 1; #1;
    check(victim_way, 0, "R10");
    @(posedge clk); model[10] = exp_update(model[10], 2'd0); #1;
    check(victim_way, 2, "R10");
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic t_mixed;
    int unsigned lcg = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      lcg = lcg * 1103515245 + 12345;
      access(int'(lcg[20:17]), lcg[25:24]);
      peek(int'(lcg[20:17]), 4'hF, "R3");
      peek(int'(lcg[12:9]), lcg[30:27], "R2");
    end
  endtask

  initial begin
    vectors = 0; miscompares = 0; finished = 0;
    t_reset;
    t_empty;
    t_walk;
    t_updates;
    t_idle;
    t_sets;
    t_timing;
    t_mixed;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL R10 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule